// File: doc/BRIEF.md
# Split Dual 8-bit Reload Timer

This block is a timer peripheral fixed in split operation: two independent 8-bit up-counters, a low half and a high half. Each half has its own reload register, its own clock-mode bit and its own sticky overflow flag. When a half is at 0xFF and receives a count tick, it wraps by loading its reload value and raises its flag. The low half counts whenever split operation is active. The high half counts only while its run bit is set.

Count ticks are single-cycle enables inside one system clock domain. A half in fast mode counts on every system clock. Otherwise one shared source-select bit picks the tick source. With the bit at 0, a free-running divide-by-12 prescaler supplies the ticks. With the bit at 1, an external clock is used: it is resynchronised through two flops, edge-detected, and divided by eight. Software writes the registers through a simple write port and reads them back through a combinational read port. Flags are cleared by writing ones. A single level interrupt request combines the two flags.

Register map (3-bit address, 8-bit data):
- 0: control. bit0 is the high-half run bit. bit1 selects the slow tick source (0 = prescaler, 1 = external). bit2 is the low-flag interrupt enable. bit3 is the interrupt enable. bit4 is the high-half fast mode. bit5 is the low-half fast mode.
- 1: flags. bit0 is the high flag and bit1 is the low flag. Writing 1 to a bit clears that flag.
- 2: low counter.
- 3: high counter.
- 4: low reload.
- 5: high reload.

Top module: `split_reload_timer`

## Requirements
- R1: After reset, both counters, both reload registers, the control register (address 0) and both flags (address 1, bit0 high and bit1 low) read zero, and `irq` is low.
- R2: On each tick, a half holding 0xFF loads its reload register (address 4 for the low half, 5 for the high half). A half holding any other value increments by one.
- R3: The high counter holds its value while control bit0 is 0 and advances on ticks while it is 1. The low counter advances on ticks with no run bit.
- R4: A half whose fast-mode bit is 1 (control bit4 for the high half, bit5 for the low half) advances on every system clock.
- R5: A half in slow mode with control bit1 at 0 advances exactly once every 12 system clocks.
- R6: A half in slow mode with control bit1 at 1 advances exactly once per 8 rising edges of `ext_clk`.
- R7: An overflow (a tick while the count is 0xFF) sets that half's flag in the same clock edge that reloads the counter.
- R8: A flag stays set until software writes 1 to its bit at address 1. If a clear and an overflow of that half happen on the same edge, the flag stays set.
- R9: `irq` is high exactly when control bit3 is 1 and either the high flag is set, or control bit2 is 1 and the low flag is set.
- R10: A register write takes effect at the clock edge that captures it. A counter write takes priority over a tick on the same edge, and that edge raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External clock, asynchronous, slower than half of clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Combined interrupt request level |

## Verification
The checker watches the following on every cycle:
- the reload on overflow for both halves;
- the frozen high counter while its run bit is 0;
- flag setting and stickiness;
- the interrupt level relative to its enables;
- the single-cycle nature of prescaler ticks.

Some properties span many cycles or depend on stimulus order, and only the bench scenarios show them. These are the exact 12-cycle and 48-cycle tick spacing, a clear that collides with an overflow, and a sweep of all 256 reload values.

// File: rtl/split_tmr_pkg.sv
package split_tmr_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD0  = 3'd4;

  // control register layout, bit5 down to bit0
  typedef struct packed {
    logic fast_lo;
    logic fast_hi;
    logic irq_en;
    logic lo_irq_en;
    logic ext_sel;
    logic run_hi;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic pick_tick(input logic fast, input logic ext_sel,
                                     input logic pre_tick, input logic ext_tick);
    if (fast) return 1'b1;
    return ext_sel ? ext_tick : pre_tick;
  endfunction

  function automatic logic [DATA_W-1:0] next_count(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] rld);
    if (cur == {DATA_W{1'b1}}) return rld;
    return cur + 1'b1;
  endfunction

  function automatic logic irq_level(input logic en, input logic lo_en,
                                     input logic f_hi, input logic f_lo);
    return en & (f_hi | (lo_en & f_lo));
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_ext_divider.sv
module tmr_ext_divider #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          div_q;
  logic                   rise;

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign tick = rise & (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (rise) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_half.sv
module tmr_half
  import split_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic              wr_rld,
  input  logic              clr_flag,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rld,
  output logic              flag,
  output logic              ovf
);
  // a counter write wins over a tick and suppresses the overflow
  assign ovf = tick & ~wr_cnt & (cnt == {DATA_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rld  <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_rld) rld <= wr_data;
      if (wr_cnt)    cnt <= wr_data;
      else if (tick) cnt <= next_count(cnt, rld);
      if (ovf)           flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import split_tmr_pkg::*;
#(
  parameter int PRE_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int NHALF = 2;  // index 0 = low half, 1 = high half

  ctrl_t ctrl_q;
  logic  pre_tick, ext_tick;

  logic [DATA_W-1:0] cnt   [NHALF];
  logic [DATA_W-1:0] rld   [NHALF];
  logic [NHALF-1:0]  flag, ovf, tick, wr_cnt, clr;
  logic [NHALF-1:0]  fast;

  assign fast = {ctrl_q.fast_hi, ctrl_q.fast_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  tmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick)
  );

  tmr_ext_divider #(.SYNC_STAGES(SYNC_STAGES), .DIV(EXT_DIV)) u_ext (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tick(ext_tick)
  );

  for (genvar i = 0; i < NHALF; i++) begin : g_half
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(A_CNT0 + i);
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(A_RLD0 + i);
    logic base_tick;

    assign base_tick = pick_tick(fast[i], ctrl_q.ext_sel, pre_tick, ext_tick);
    if (i == 1) begin : g_run
      assign tick[i] = base_tick & ctrl_q.run_hi;
    end else begin : g_free
      assign tick[i] = base_tick;
    end

    assign wr_cnt[i] = wr_en && (wr_addr == A_CNT);
    // flag bit 0 is the high half, bit 1 the low half
    assign clr[i]    = wr_en && (wr_addr == A_FLAGS) && wr_data[NHALF-1-i];

    tmr_half u_half (
      .clk(clk), .rst_n(rst_n), .tick(tick[i]),
      .wr_cnt(wr_cnt[i]), .wr_rld(wr_en && (wr_addr == A_RLD)),
      .clr_flag(clr[i]), .wr_data(wr_data),
      .cnt(cnt[i]), .rld(rld[i]), .flag(flag[i]), .ovf(ovf[i])
    );
  end

  assign irq = irq_level(ctrl_q.irq_en, ctrl_q.lo_irq_en, flag[1], flag[0]);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:           rd_data = DATA_W'(ctrl_q);
      A_FLAGS:          rd_data = DATA_W'({flag[0], flag[1]});
      A_CNT0:           rd_data = cnt[0];
      A_CNT0 + 3'd1:    rd_data = cnt[1];
      A_RLD0:           rd_data = rld[0];
      A_RLD0 + 3'd1:    rd_data = rld[1];
      default:          rd_data = '0;
    endcase
  end

  // named event wires for the bound checker
  logic ovf_lo, ovf_hi, tick_lo_w, tick_hi_w;
  assign ovf_lo    = ovf[0];
  assign ovf_hi    = ovf[1];
  assign tick_lo_w = tick[0];
  assign tick_hi_w = tick[1];
endmodule

// File: rtl/split_reload_timer_chk.sv
module split_reload_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_hi,
  input logic       irq_en,
  input logic       irq,
  input logic       pre_tick,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic [7:0] rld_lo,
  input logic [7:0] rld_hi,
  input logic       wr_cnt_lo,
  input logic       wr_cnt_hi,
  input logic       ovf_lo,
  input logic       ovf_hi,
  input logic       flag_lo,
  input logic       flag_hi,
  input logic       clr_lo,
  input logic       clr_hi
);
  a_r2_lo_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo |=> cnt_lo == $past(rld_lo));
  a_r2_hi_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi |=> cnt_hi == $past(rld_hi));
  a_r3_hi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_hi && !wr_cnt_hi) |=> $stable(cnt_hi));
  a_r7_lo_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_lo |=> flag_lo);
  a_r7_hi_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hi |=> flag_hi);
  a_r8_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_lo && !clr_lo) |=> flag_lo);
  a_r8_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !clr_hi) |=> flag_hi);
  a_r9_irq_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && flag_hi) |-> irq);
  a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  a_r5_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);
  a_r10_wr_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_lo |=> !$past(ovf_lo));
endmodule

bind split_reload_timer split_reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_hi(ctrl_q.run_hi), .irq_en(ctrl_q.irq_en),
  .irq(irq), .pre_tick(pre_tick),
  .cnt_lo(cnt[0]), .cnt_hi(cnt[1]), .rld_lo(rld[0]), .rld_hi(rld[1]),
  .wr_cnt_lo(wr_cnt[0]), .wr_cnt_hi(wr_cnt[1]),
  .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .flag_lo(flag[0]), .flag_hi(flag[1]),
  .clr_lo(clr[0]), .clr_hi(clr[1])
);

// File: tb/split_reload_timer_bench.sv
module split_reload_timer_bench;
  logic       clk = 0, rst_n = 0, ext_clk = 0, wr_en = 0, irq;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int total = 0, bad = 0;

  split_reload_timer u_split_reload_timer (.*);

  always #10 clk = ~clk;
  initial begin #5; forever #60 ext_clk = ~ext_clk; end  // 6 clk per period

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic gap(output int n);
    logic [7:0] v0, v;
    rd(3'd2, v0); n = 0;
    do begin @(negedge clk); n++; rd(3'd2, v); end while (v == v0);
  endtask

  logic [7:0] v;
  int n;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R1 reg", v, 0); end
    chk("R1 irq", irq, 0);

    // R4 fast low half
    wr(3'd0, 8'h20); wr(3'd2, 8'h10);
    for (int k = 0; k < 5; k++) begin
      rd(3'd2, v); chk("R4 lo step", v, 8'h10 + k); @(negedge clk);
    end

    // R2 / R7 overflow with reload
    wr(3'd4, 8'hF0); wr(3'd2, 8'hFE);
    rd(3'd2, v); chk("R10 write", v, 8'hFE);
    @(negedge clk); rd(3'd2, v); chk("R2 lo FF", v, 8'hFF);
    @(negedge clk); rd(3'd2, v); chk("R2 lo reload", v, 8'hF0);
    rd(3'd1, v); chk("R7 lo flag", v[1], 1);

    // R9 irq combinations
    chk("R9 en off", irq, 0);
    wr(3'd0, 8'h28); chk("R9 lo not enabled", irq, 0);
    wr(3'd0, 8'h2C); chk("R9 lo enabled", irq, 1);
    wr(3'd0, 8'h20);

    // R8 clear and collision
    wr(3'd2, 8'h00);
    repeat (20) @(negedge clk);
    rd(3'd1, v); chk("R8 sticky", v[1], 1);
    wr(3'd1, 8'h02); rd(3'd1, v); chk("R8 cleared", v[1], 0);
    wr(3'd2, 8'hFF);
    wr_en = 1; wr_addr = 3'd1; wr_data = 8'h02;
    @(negedge clk); wr_en = 0;
    rd(3'd1, v); chk("R8 clear vs overflow", v[1], 1);
    rd(3'd2, v); chk("R2 lo after collision", v, 8'hF0);

    // R3 high half run control
    wr(3'd0, 8'h10); wr(3'd3, 8'h40);
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk("R3 hi held", v, 8'h40);
    wr(3'd0, 8'h11); rd(3'd3, v); chk("R3 hi run edge", v, 8'h40);
    @(negedge clk); rd(3'd3, v); chk("R3 hi runs", v, 8'h41);
    wr(3'd5, 8'h80); wr(3'd3, 8'hFE);
    @(negedge clk); @(negedge clk);
    rd(3'd3, v); chk("R2 hi reload", v, 8'h80);
    rd(3'd1, v); chk("R7 hi flag", v[0], 1);
    wr(3'd0, 8'h19); chk("R9 hi irq", irq, 1);

    // R5 prescaler spacing, R6 external spacing
    wr(3'd0, 8'h00);
    gap(n); gap(n); chk("R5 gap", n, 12); gap(n); chk("R5 gap", n, 12);
    wr(3'd0, 8'h02);
    gap(n); gap(n); chk("R6 gap", n, 48); gap(n); chk("R6 gap", n, 48);

    // R2 reload sweep over every value
    wr(3'd0, 8'h20);
    for (int r = 0; r < 256; r++) begin
      wr(3'd4, 8'(r)); wr(3'd2, 8'hFF);
      @(negedge clk); rd(3'd2, v); chk("R2 sweep wrap", v, r);
      @(negedge clk); rd(3'd2, v); chk("R2 sweep next", v, (r == 255) ? 255 : r + 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule